// File: doc/BRIEF.md
# Direct-Mapped Write-Back Byte Cache

This block is a byte-wide data cache between a processor port and a next-level memory that moves whole lines. It is direct-mapped, with 64 sets of 64-byte lines. A processor request is a 32-bit address, a write strobe and one data byte, qualified by a request strobe. Hits are served without stalling. A read hit returns its byte one cycle later, and a write hit updates the stored line and marks it modified.

On a miss the block drops its ready output and works through the next level with a valid/ready handshake that carries a 2-bit command, a line-aligned address and a 512-bit line. If the set already holds a modified line, that line is first written out to the address rebuilt from its stored tag. The wanted line is then fetched. A clean or empty victim is simply overwritten. A write that misses fetches the line first and then merges its byte into it, so the line ends up resident and modified.

Two event counters are brought out as outputs. One counts line fills and the other counts write-outs of modified victims.

Top module: `wb_byte_cache`

## Requirements
- R1: After reset, cpu_ready is high, both counters read zero, mem_valid is low with mem_cmd = 0, and every set is empty, so the first access to any address misses.
- R2: The byte offset is address bits [5:0], the set index is bits [11:6] and the tag is bits [31:12]. Every next-level address is line-aligned: {tag, index, 6'b0}.
- R3: A read that hits, accepted on a clock edge with cpu_valid and cpu_ready high, shows its byte on cpu_rdata in the following cycle. cpu_ready stays high and no next-level request is made.
- R4: A write that hits replaces the addressed byte, which is seen by a later read, and marks the line modified. No next-level request is made.
- R5: A miss whose set is empty or holds an unmodified line drops cpu_ready, issues a single READ (mem_cmd = 1) and no WRITE, and leaves evict_count unchanged. cpu_ready rises in the cycle after the READ handshake.
- R6: Line data is little-endian: byte k of a line sits in bits [8k+7:8k]. For a read miss, the requested byte of the fetched line appears on cpu_rdata in the cycle after the READ handshake.
- R7: A miss whose set holds a modified line first issues a WRITE (mem_cmd = 2) carrying that line's current contents to its rebuilt address, then a READ for the new line. evict_count rises by one on the WRITE handshake.
- R8: A write that misses fetches the line, merges its byte into the fetched data and leaves the line modified, so a later eviction writes out the merged line.
- R9: miss_count rises by exactly one on each READ handshake and is unchanged in every other cycle.
- R10: A next-level request keeps mem_valid, mem_cmd, mem_addr and mem_wdata unchanged until the cycle in which mem_ready is high. Fill data is taken in that same cycle.
- R11: Writing one byte into each of N distinct lines, laid out so that every set is used, gives N misses and N - 64 evictions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cpu_valid | input | 1 | Processor request strobe |
| cpu_addr | input | 32 | Processor byte address |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_wdata | input | 8 | Byte to write |
| cpu_ready | output | 1 | High when a request can be accepted |
| cpu_rdata | output | 8 | Read byte, registered |
| mem_valid | output | 1 | Next-level request valid |
| mem_cmd | output | 2 | 0 none, 1 read, 2 write |
| mem_addr | output | 32 | Line-aligned next-level address |
| mem_wdata | output | 512 | Line written out, little-endian bytes |
| mem_ready | input | 1 | Next-level completion, one cycle |
| mem_rdata | input | 512 | Fill line, valid while mem_ready is high |
| miss_count | output | 32 | Number of line fills |
| evict_count | output | 32 | Number of modified-line write-outs |

## Verification
The assertions assume that the next level raises mem_ready only while mem_valid is high and holds it for a single cycle, and that mem_rdata is valid in that same cycle. They also assume that cpu_valid is only meaningful while cpu_ready is high. The bench responder keeps to these rules: it waits a set number of cycles after it sees a request, pulses ready once and then drops it. The processor driver presents a request only in a cycle where it has seen cpu_ready high, and it withdraws the strobe just after the accepting edge. The responder latency is varied from phase to phase, including zero, so that stability of the held request is exercised.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

  // Next-level command encoding; the responder decodes these values.
  typedef enum logic [1:0] {
    MCMD_NONE  = 2'd0,
    MCMD_READ  = 2'd1,
    MCMD_WRITE = 2'd2
  } mem_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EVICT = 2'd1,
    ST_FILL  = 2'd2
  } ctrl_state_e;

endpackage

// File: rtl/wbc_tag_store.sv
module wbc_tag_store #(
  parameter int NUM_SETS = 64,
  parameter int TAG_W    = 20,
  localparam int IDX_W   = $clog2(NUM_SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] lk_idx,
  output logic             lk_valid,
  output logic             lk_dirty,
  output logic [TAG_W-1:0] lk_tag,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             fill_dirty,
  input  logic             mark_en,
  input  logic [IDX_W-1:0] mark_idx
);

  logic [NUM_SETS-1:0] valid_q;
  logic [NUM_SETS-1:0] dirty_q;
  logic [TAG_W-1:0]    tag_q [NUM_SETS];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill_en) begin
      valid_q[fill_idx] <= 1'b1;
      dirty_q[fill_idx] <= fill_dirty;
    end else if (mark_en) begin
      dirty_q[mark_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[fill_idx] <= fill_tag;
  end

  assign lk_valid = valid_q[lk_idx];
  assign lk_dirty = dirty_q[lk_idx];
  assign lk_tag   = tag_q[lk_idx];

  // R4: only a resident line may be marked modified by a hit write
  assert_dirty_needs_valid_R4: assert property (@(posedge clk) disable iff (rst)
    mark_en |-> valid_q[mark_idx]);

  // R1/R5: a fill never lands on the same set as a concurrent hit mark
  assert_no_mark_during_fill_R5: assert property (@(posedge clk) disable iff (rst)
    fill_en |-> !mark_en);

endmodule

// File: rtl/wbc_line_store.sv
module wbc_line_store #(
  parameter int NUM_SETS   = 64,
  parameter int LINE_BYTES = 64,
  localparam int IDX_W     = $clog2(NUM_SETS),
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LINE_W    = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [LINE_W-1:0] rd_line,
  input  logic              line_we,
  input  logic [IDX_W-1:0]  line_idx,
  input  logic [LINE_W-1:0] line_data,
  input  logic              byte_we,
  input  logic [IDX_W-1:0]  byte_idx,
  input  logic [OFF_W-1:0]  byte_off,
  input  logic [7:0]        byte_data
);

  logic [LINE_W-1:0] lines_q [NUM_SETS];

  always_ff @(posedge clk) begin
    if (line_we)
      lines_q[line_idx] <= line_data;
    else if (byte_we)
      lines_q[byte_idx][{byte_off, 3'b000} +: 8] <= byte_data;
  end

  assign rd_line = lines_q[rd_idx];

endmodule

// File: rtl/wbc_event_ctr.sv
module wbc_event_ctr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst)      count <= '0;
    else if (inc) count <= count + 1'b1;
  end

endmodule

// File: rtl/wbc_ctrl.sv
module wbc_ctrl
  import wbc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NUM_SETS   = 64,
  parameter int LINE_BYTES = 64,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int IDX_W     = $clog2(NUM_SETS),
  localparam int TAG_W     = ADDR_W - IDX_W - OFF_W,
  localparam int LINE_W    = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_valid,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_we,
  input  logic [7:0]        cpu_wdata,
  output logic              cpu_ready,
  output logic [7:0]        cpu_rdata,
  output logic [IDX_W-1:0]  lk_idx,
  input  logic              lk_valid,
  input  logic              lk_dirty,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              fill_en,
  output logic [TAG_W-1:0]  fill_tag,
  output logic              fill_dirty,
  output logic              mark_en,
  input  logic [LINE_W-1:0] rd_line,
  output logic [LINE_W-1:0] line_data,
  output logic [OFF_W-1:0]  cpu_off,
  output logic              mem_valid,
  output mem_cmd_e          mem_cmd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LINE_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [LINE_W-1:0] mem_rdata,
  output logic              ev_fill,
  output logic              ev_evict
);

  // ---- address arithmetic ----
  function automatic logic [OFF_W-1:0] off_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W-1:0];
  endfunction

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [ADDR_W-1:0] line_base(input logic [TAG_W-1:0] t,
                                                  input logic [IDX_W-1:0] i);
    return {t, i, {OFF_W{1'b0}}};
  endfunction

  function automatic logic [7:0] byte_of(input logic [LINE_W-1:0] l,
                                         input logic [OFF_W-1:0]  o);
    return l[{o, 3'b000} +: 8];
  endfunction

  function automatic logic [LINE_W-1:0] merge_byte(input logic [LINE_W-1:0] l,
                                                   input logic [OFF_W-1:0]  o,
                                                   input logic [7:0]        b);
    logic [LINE_W-1:0] r;
    r = l;
    r[{o, 3'b000} +: 8] = b;
    return r;
  endfunction

  // ---- state ----
  ctrl_state_e       state_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic              pend_we_q;
  logic [7:0]        pend_data_q;

  // ---- named events ----
  logic idle, accept, hit, acc_hit, acc_miss, victim_dirty;
  logic evict_done, fill_done;

  assign idle         = (state_q == ST_IDLE);
  assign accept       = idle && cpu_valid;
  assign hit          = lk_valid && (lk_tag == tag_of(cpu_addr));
  assign acc_hit      = accept && hit;
  assign acc_miss     = accept && !hit;
  assign victim_dirty = lk_valid && lk_dirty;
  assign evict_done   = (state_q == ST_EVICT) && mem_ready;
  assign fill_done    = (state_q == ST_FILL)  && mem_ready;

  assign cpu_ready = idle;
  assign lk_idx    = idle ? idx_of(cpu_addr) : idx_of(pend_addr_q);
  assign cpu_off   = off_of(cpu_addr);

  // hit write goes straight into the line store
  assign mark_en = acc_hit && cpu_we;

  // fill writes the whole line, merged with a pending byte write
  assign fill_en    = fill_done;
  assign fill_tag   = tag_of(pend_addr_q);
  assign fill_dirty = pend_we_q;
  assign line_data  = pend_we_q ? merge_byte(mem_rdata, off_of(pend_addr_q), pend_data_q)
                                : mem_rdata;

  // next-level request, a pure function of state and held request
  always_comb begin
    mem_valid = 1'b0;
    mem_cmd   = MCMD_NONE;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state_q)
      ST_EVICT: begin
        mem_valid = 1'b1;
        mem_cmd   = MCMD_WRITE;
        mem_addr  = line_base(lk_tag, idx_of(pend_addr_q));
        mem_wdata = rd_line;
      end
      ST_FILL: begin
        mem_valid = 1'b1;
        mem_cmd   = MCMD_READ;
        mem_addr  = line_base(tag_of(pend_addr_q), idx_of(pend_addr_q));
      end
      default: ;
    endcase
  end

  assign ev_fill  = fill_done;
  assign ev_evict = evict_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      pend_addr_q <= '0;
      pend_we_q   <= 1'b0;
      pend_data_q <= '0;
      cpu_rdata   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (acc_hit && !cpu_we)
            cpu_rdata <= byte_of(rd_line, off_of(cpu_addr));
          if (acc_miss) begin
            pend_addr_q <= cpu_addr;
            pend_we_q   <= cpu_we;
            pend_data_q <= cpu_wdata;
            state_q     <= victim_dirty ? ST_EVICT : ST_FILL;
          end
        end
        ST_EVICT: begin
          if (evict_done) state_q <= ST_FILL;
        end
        ST_FILL: begin
          if (fill_done) begin
            state_q <= ST_IDLE;
            if (!pend_we_q)
              cpu_rdata <= byte_of(mem_rdata, off_of(pend_addr_q));
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R3: a hit makes no next-level request and keeps the port open
  assert_hit_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (cpu_valid && cpu_ready && hit) |=> (!mem_valid && cpu_ready));

  // R5: a miss stalls the processor and opens a request
  assert_miss_stalls_R5: assert property (@(posedge clk) disable iff (rst)
    (cpu_valid && cpu_ready && !hit) |=> (!cpu_ready && mem_valid));

  // R5/R6: the fill handshake releases the processor port
  assert_fill_releases_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_ready && mem_cmd == MCMD_READ) |=> cpu_ready);

  // R7: a write-out is always followed by the refill read
  assert_wb_then_read_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_ready && mem_cmd == MCMD_WRITE) |=> (mem_valid && mem_cmd == MCMD_READ));

  // R10: a request is held unchanged while the next level is not ready
  assert_req_held_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_cmd) && $stable(mem_addr)
                                   && $stable(mem_wdata)));

endmodule

// File: rtl/wb_byte_cache.sv
module wb_byte_cache
  import wbc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NUM_SETS   = 64,
  parameter int LINE_BYTES = 64,
  parameter int CNT_W      = 32,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int IDX_W     = $clog2(NUM_SETS),
  localparam int TAG_W     = ADDR_W - IDX_W - OFF_W,
  localparam int LINE_W    = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_valid,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_we,
  input  logic [7:0]        cpu_wdata,
  output logic              cpu_ready,
  output logic [7:0]        cpu_rdata,
  output logic              mem_valid,
  output logic [1:0]        mem_cmd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LINE_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [LINE_W-1:0] mem_rdata,
  output logic [CNT_W-1:0]  miss_count,
  output logic [CNT_W-1:0]  evict_count
);

  logic [IDX_W-1:0]  lk_idx;
  logic              lk_valid, lk_dirty;
  logic [TAG_W-1:0]  lk_tag;
  logic              fill_en, fill_dirty, mark_en;
  logic [TAG_W-1:0]  fill_tag;
  logic [LINE_W-1:0] rd_line, line_data;
  logic [OFF_W-1:0]  cpu_off;
  logic              ev_fill, ev_evict;
  mem_cmd_e          cmd_e;

  wbc_ctrl #(.ADDR_W(ADDR_W), .NUM_SETS(NUM_SETS), .LINE_BYTES(LINE_BYTES)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cpu_valid  (cpu_valid),
    .cpu_addr   (cpu_addr),
    .cpu_we     (cpu_we),
    .cpu_wdata  (cpu_wdata),
    .cpu_ready  (cpu_ready),
    .cpu_rdata  (cpu_rdata),
    .lk_idx     (lk_idx),
    .lk_valid   (lk_valid),
    .lk_dirty   (lk_dirty),
    .lk_tag     (lk_tag),
    .fill_en    (fill_en),
    .fill_tag   (fill_tag),
    .fill_dirty (fill_dirty),
    .mark_en    (mark_en),
    .rd_line    (rd_line),
    .line_data  (line_data),
    .cpu_off    (cpu_off),
    .mem_valid  (mem_valid),
    .mem_cmd    (cmd_e),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ready  (mem_ready),
    .mem_rdata  (mem_rdata),
    .ev_fill    (ev_fill),
    .ev_evict   (ev_evict)
  );

  assign mem_cmd = cmd_e;

  wbc_tag_store #(.NUM_SETS(NUM_SETS), .TAG_W(TAG_W)) u_tags (
    .clk        (clk),
    .rst        (rst),
    .lk_idx     (lk_idx),
    .lk_valid   (lk_valid),
    .lk_dirty   (lk_dirty),
    .lk_tag     (lk_tag),
    .fill_en    (fill_en),
    .fill_idx   (lk_idx),
    .fill_tag   (fill_tag),
    .fill_dirty (fill_dirty),
    .mark_en    (mark_en),
    .mark_idx   (lk_idx)
  );

  wbc_line_store #(.NUM_SETS(NUM_SETS), .LINE_BYTES(LINE_BYTES)) u_lines (
    .clk       (clk),
    .rd_idx    (lk_idx),
    .rd_line   (rd_line),
    .line_we   (fill_en),
    .line_idx  (lk_idx),
    .line_data (line_data),
    .byte_we   (mark_en),
    .byte_idx  (lk_idx),
    .byte_off  (cpu_off),
    .byte_data (cpu_wdata)
  );

  wbc_event_ctr #(.W(CNT_W)) u_miss_ctr (
    .clk   (clk),
    .rst   (rst),
    .inc   (ev_fill),
    .count (miss_count)
  );

  wbc_event_ctr #(.W(CNT_W)) u_evict_ctr (
    .clk   (clk),
    .rst   (rst),
    .inc   (ev_evict),
    .count (evict_count)
  );

  // R7: each write-out handshake adds one eviction
  assert_evict_step_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_ready && mem_cmd == 2'd2) |=> (evict_count == $past(evict_count) + 1'b1));

  // R9: each read handshake adds one miss
  assert_miss_step_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_ready && mem_cmd == 2'd1) |=> (miss_count == $past(miss_count) + 1'b1));

  // R9: no other cycle moves the miss counter
  assert_miss_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !(mem_valid && mem_ready && mem_cmd == 2'd1) |=> $stable(miss_count));

  // R1/R10: the idle command is NONE
  assert_idle_cmd_R10: assert property (@(posedge clk) disable iff (rst)
    !mem_valid |-> (mem_cmd == 2'd0));

endmodule

// File: tb/wb_byte_cache_tb.sv
module wb_byte_cache_tb;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cpu_valid = 1'b0;
  logic [31:0]  cpu_addr = '0;
  logic         cpu_we = 1'b0;
  logic [7:0]   cpu_wdata = '0;
  logic         cpu_ready;
  logic [7:0]   cpu_rdata;
  logic         mem_valid;
  logic [1:0]   mem_cmd;
  logic [31:0]  mem_addr;
  logic [511:0] mem_wdata;
  logic         mem_ready = 1'b0;
  logic [511:0] mem_rdata = '0;
  logic [31:0]  miss_count, evict_count;

  always #5 clk = ~clk;

  wb_byte_cache u_dut (
    .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mem_valid(mem_valid), .mem_cmd(mem_cmd), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .miss_count(miss_count),
    .evict_count(evict_count)
  );

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference memory system (what the processor must observe) and backing lines
  logic [7:0]   shadow [int unsigned];
  logic [511:0] bk [int unsigned];
  logic [39:0]  exp_q [$];

  int          lat = 0;
  int          n_rd = 0, n_wr = 0;
  logic [31:0] last_rd = '0, last_wr = '0;
  int          last_cmd = 0, prev_cmd = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat_byte(input logic [31:0] a);
    logic [7:0] r;
    r = a[7:0] * 8'd3;
    return r ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] ref_byte(input logic [31:0] a);
    if (shadow.exists(a)) return shadow[a];
    return pat_byte(a);
  endfunction

  function automatic logic [511:0] ref_line(input logic [31:0] base);
    logic [511:0] l;
    for (int k = 0; k < 64; k++) l[k*8 +: 8] = ref_byte(base + k);
    return l;
  endfunction

  function automatic logic [511:0] bk_line(input logic [31:0] base);
    logic [511:0] l;
    if (bk.exists(base)) return bk[base];
    for (int k = 0; k < 64; k++) l[k*8 +: 8] = pat_byte(base + k);
    return l;
  endfunction

  // next-level responder (R10 hold checks, R7/R8 write-out data checks)
  initial begin : responder
    int          wcnt;
    logic [31:0] h_addr;
    logic [1:0]  h_cmd;
    wcnt = 0;
    h_addr = '0;
    h_cmd = '0;
    forever begin
      @(negedge clk);
      if (rst) begin
        mem_ready = 1'b0;
        wcnt = 0;
      end else if (mem_ready) begin
        mem_ready = 1'b0;
        wcnt = 0;
      end else if (mem_valid) begin
        if (wcnt == 0) begin
          h_addr = mem_addr;
          h_cmd  = mem_cmd;
        end else begin
          chk(mem_addr == h_addr && mem_cmd == h_cmd, "R10 held request",
              {30'd0, mem_cmd, mem_addr}, {30'd0, h_cmd, h_addr});
        end
        if (wcnt >= lat) begin
          mem_ready = 1'b1;
          prev_cmd = last_cmd;
          if (mem_cmd == 2'd1) begin
            mem_rdata = bk_line(mem_addr);
            n_rd++;
            last_rd = mem_addr;
            last_cmd = 1;
          end else begin
            chk(mem_wdata == ref_line(mem_addr), "R7 write-out line data",
                mem_wdata[63:0], ref_line(mem_addr) >> 0);
            bk[mem_addr] = mem_wdata;
            n_wr++;
            last_wr = mem_addr;
            last_cmd = 2;
          end
        end else begin
          wcnt++;
        end
      end
    end
  end

  // scoreboard monitor: pops expected read bytes when results appear
  initial begin : monitor
    logic [39:0] item;
    forever begin
      @(negedge clk);
      if (!rst && exp_q.size() > 0 && cpu_ready) begin
        item = exp_q.pop_front();
        chk(cpu_rdata == item[7:0], "R3/R6 read byte", {56'd0, cpu_rdata},
            {56'd0, item[7:0]});
      end
    end
  end

  // driver: present a request when ready, record its expectation
  task automatic cpu_op(input logic [31:0] a, input logic we, input logic [7:0] d);
    @(negedge clk);
    while (!cpu_ready) @(negedge clk);
    cpu_valid = 1'b1;
    cpu_addr  = a;
    cpu_we    = we;
    cpu_wdata = d;
    @(posedge clk);
    #1;
    cpu_valid = 1'b0;
    if (we) shadow[a] = d;
    else    exp_q.push_back({a, ref_byte(a)});
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!cpu_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cpu_valid = 1'b0;
    shadow.delete();
    bk.delete();
    exp_q.delete();
    n_rd = 0; n_wr = 0; last_cmd = 0; prev_cmd = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin : watchdog
    #1_500_000;
    vectors++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin : main
    int rd0, wr0;
    logic [31:0] ev0, ms0;

    // ---- R1: reset state ----
    do_reset();
    @(negedge clk);
    chk(cpu_ready == 1'b1, "R1 ready after reset", {63'd0, cpu_ready}, 64'd1);
    chk(miss_count == 0 && evict_count == 0, "R1 counters cleared",
        {miss_count, evict_count}, 64'd0);
    chk(mem_valid == 1'b0 && mem_cmd == 2'd0, "R1 idle request",
        {61'd0, mem_valid, mem_cmd}, 64'd0);

    // ---- R5/R6/R2: read miss on empty set ----
    lat = 2;
    cpu_op(32'h0000_0100, 1'b0, 8'h00);
    wait_idle();
    chk(n_rd == 1 && n_wr == 0, "R5 single read, no write", {32'(n_rd), 32'(n_wr)},
        {32'd1, 32'd0});
    chk(last_rd == 32'h0000_0100, "R2 line-aligned read address", {32'd0, last_rd},
        64'h100);
    chk(miss_count == 1 && evict_count == 0, "R9 miss count after fill",
        {miss_count, evict_count}, {32'd1, 32'd0});

    // ---- R3/R6: read hit on top byte, no traffic ----
    rd0 = n_rd; wr0 = n_wr;
    cpu_op(32'h0000_013F, 1'b0, 8'h00);
    cpu_op(32'h0000_0105, 1'b0, 8'h00);
    wait_idle();
    chk(n_rd == rd0 && n_wr == wr0, "R3 hit makes no request", {32'(n_rd), 32'(n_wr)},
        {32'(rd0), 32'(wr0)});

    // ---- R4: write hit, then read back ----
    cpu_op(32'h0000_0101, 1'b1, 8'hBB);
    cpu_op(32'h0000_0101, 1'b0, 8'h00);
    cpu_op(32'h0000_0102, 1'b0, 8'h00);
    wait_idle();
    chk(n_rd == rd0 && n_wr == wr0, "R4 write hit makes no request",
        {32'(n_rd), 32'(n_wr)}, {32'(rd0), 32'(wr0)});

    // ---- R7: dirty victim written out, then refill ----
    lat = 3;
    cpu_op(32'h0000_1100, 1'b0, 8'h00);
    wait_idle();
    chk(evict_count == 1 && miss_count == 2, "R7 eviction counted",
        {miss_count, evict_count}, {32'd2, 32'd1});
    chk(last_wr == 32'h0000_0100, "R7 rebuilt victim address", {32'd0, last_wr}, 64'h100);
    chk(prev_cmd == 2 && last_cmd == 1, "R7 write before read",
        {32'(prev_cmd), 32'(last_cmd)}, {32'd2, 32'd1});

    // ---- R5: clean victim replaced silently ----
    wr0 = n_wr;
    cpu_op(32'h0000_2100, 1'b0, 8'h00);
    wait_idle();
    chk(n_wr == wr0 && evict_count == 1, "R5 clean victim not written",
        {32'(n_wr), evict_count}, {32'(wr0), 32'd1});
    chk(last_rd == 32'h0000_2100, "R2 read address of new tag", {32'd0, last_rd},
        64'h2100);

    // ---- R8: write-allocate and merge ----
    lat = 0;
    cpu_op(32'h0000_3205, 1'b1, 8'h5A);
    wait_idle();
    chk(miss_count == 4, "R8 write miss fills", {32'd0, miss_count}, 64'd4);
    cpu_op(32'h0000_3205, 1'b0, 8'h00);
    cpu_op(32'h0000_3206, 1'b0, 8'h00);
    cpu_op(32'h0000_4200, 1'b0, 8'h00);
    wait_idle();
    chk(last_wr == 32'h0000_3200 && evict_count == 2, "R8 merged line is modified",
        {last_wr, evict_count}, {32'h3200, 32'd2});

    // ---- R1 again, then R11 sweep over 128 lines ----
    do_reset();
    @(negedge clk);
    chk(miss_count == 0 && evict_count == 0, "R1 counters cleared on second reset",
        {miss_count, evict_count}, 64'd0);
    lat = 1;
    for (int i = 0; i < 128; i++)
      cpu_op(32'h0001_0000 + 32'(i) * 32'd64, 1'b1, 8'(i));
    wait_idle();
    chk(miss_count == 128 && evict_count == 64, "R11 sweep counts",
        {miss_count, evict_count}, {32'd128, 32'd64});
    chk(last_wr == 32'h0001_0000 + 32'd63 * 32'd64, "R11 last write-out address",
        {32'd0, last_wr}, {32'd0, 32'h0001_0000 + 32'd63 * 32'd64});
    ev0 = evict_count; ms0 = miss_count;
    cpu_op(32'h0001_0000 + 32'd5 * 32'd64, 1'b0, 8'h00);
    wait_idle();
    chk(evict_count == ev0 + 1 && miss_count == ms0 + 1, "R9 refetch of evicted line",
        {miss_count, evict_count}, {ms0 + 32'd1, ev0 + 32'd1});
    chk(exp_q.size() == 0, "R3 all reads answered", 64'(exp_q.size()), 64'd0);

    finish_run();
  end

endmodule